// File: doc/BRIEF.md
# Radio Packet FIFO with Interrupt Flags

This block is a byte-wide FIFO placed between a host register port and a bit-serial shift path that feeds or drains a radio modem. It works in one of four modes. In receive mode, a deserialiser collects bits on each bit-clock enable and pushes each finished byte into the FIFO. In standby and transmit modes, the host writes bytes into the FIFO. In transmit mode, a serialiser pops those bytes and sends them out one bit at a time.

The block drives six status lines for the host's interrupt logic: an active-low empty line, a full line, a one-bit-period pulse for each received byte, a flag that compares the fill level with a programmable level, a sticky overrun flag, and a transmit-complete flag. The FIFO empties itself on certain mode changes. Which changes flush it depends on the packet/buffered selection. A write-one-to-clear strobe for the overrun flag also flushes the FIFO and restarts both shift paths.

Top module: `radio_fifo_irq`

## Requirements
- R1: `emptyN` is 0 whenever the FIFO holds no byte and 1 otherwise. After reset the FIFO is empty and `full`, `overrun`, `txDone`, `txBitValid` and `wrBytePulse` are all 0.
- R2: `full` is 1 exactly when all DEPTH locations (default 64) are occupied.
- R3: `threshHit` is 0 while the byte count is at most `threshVal` and 1 once the count is `threshVal`+1 or more.
- R4: In receive mode (`mode`=2), each `bitTick` cycle shifts `rxBit` in, most significant bit first. The 8th tick pushes the assembled byte. `wrBytePulse` rises at that edge and falls at the next `bitTick` edge.
- R5: Host writes are accepted only in standby (`mode`=1) and transmit (`mode`=3). In sleep (`mode`=0) and receive they are ignored. A host read pops the head in every mode except transmit. `hostRdData` shows the head byte, and shows 0x00 with nothing popped when the FIFO is empty.
- R6: A push that arrives while the FIFO is full, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` stays set until it is cleared.
- R7: A cycle with `ovrClrWr`=1 clears `overrun`, empties the FIFO and restarts both shift paths, whether or not an overrun occurred.
- R8: When `mode` changes, the FIFO is flushed on standby→receive, receive→transmit, transmit→receive and any→sleep. It keeps its contents on receive→standby and transmit→standby.
- R9: On standby→transmit, the FIFO is flushed when `packetMode`=0 (buffered) and kept when `packetMode`=1.
- R10: In transmit mode the serialiser loads the head byte when idle. It presents bit 7 first on `txBit` and moves to the next bit on each `bitTick`. It loads the following byte at the tick that ends the 8th bit. `txBitValid` is 1 while a byte is being sent.
- R11: `txDone` sets at the tick that ends the last bit when the FIFO is empty. It clears on the next load, on a mode change or on `ovrClrWr`.
- R12: A push and a pop in the same cycle on a full FIFO act as a pop followed by a push: the count stays at DEPTH and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode: 0 sleep, 1 standby, 2 receive, 3 transmit |
| packetMode | input | 1 | 1 keeps a preloaded packet on standby→transmit |
| bitTick | input | 1 | Bit-clock enable for the shift paths |
| rxBit | input | 1 | Serial receive data |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host byte read strobe |
| hostRdData | output | 8 | Head byte, 0x00 when empty |
| ovrClrWr | input | 1 | Write-one strobe clearing overrun and flushing |
| threshVal | input | 7 | Programmable fill threshold |
| txBit | output | 1 | Serial transmit data |
| txBitValid | output | 1 | Transmit bit is valid |
| emptyN | output | 1 | Low when FIFO empty |
| full | output | 1 | FIFO full |
| wrBytePulse | output | 1 | Received-byte pulse, one bit period long |
| threshHit | output | 1 | Count above threshold |
| overrun | output | 1 | Sticky overrun flag |
| txDone | output | 1 | Last transmit bit sent with FIFO empty |

## Verification
A wrong pointer or count shows up at the flags on the very next cycle: `emptyN`, `full` and `threshHit` all decode the count directly. A wrong pointer also shows up at `hostRdData`, because the bench keeps a reference queue and compares every byte it reads. Missing or extra mode-change flushes show up in the first flag sample after the change. Ordering faults in the serialiser show on `txBit` within the bit period in which they occur. A lost or stretched received-byte pulse shows on `wrBytePulse` before the next bit tick.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_RX    = 2'd2,
    MODE_TX    = 2'd3
  } rfifo_mode_e;

  typedef struct packed {
    logic       push;
    logic [7:0] pushData;
    logic       pop;
    logic       flush;
    logic       ovrClear;
  } fifo_strobe_t;

  // Decides whether a mode switch empties the FIFO.
  function automatic logic flushOnSwitch(input rfifo_mode_e fromMode,
                                         input rfifo_mode_e toMode,
                                         input logic packetSel);
    logic res;
    res = 1'b0;
    if (toMode == MODE_SLEEP) res = 1'b1;
    else begin
      case (fromMode)
        MODE_STBY: res = (toMode == MODE_RX) || ((toMode == MODE_TX) && !packetSel);
        MODE_RX:   res = (toMode == MODE_TX);
        MODE_TX:   res = (toMode == MODE_RX);
        default:   res = 1'b0;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/rfifo_datapath.sv
module rfifo_datapath
  import rfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  output logic [CNT_W-1:0] fifoCount,
  output logic [7:0]       headData,
  output logic             overrunFlag
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          isFull, isEmpty, doPop, doPush, dropByte;

  assign isFull   = (fifoCount == FULL_CNT);
  assign isEmpty  = (fifoCount == '0);
  assign doPop    = strobe.pop && !isEmpty;
  assign doPush   = strobe.push && (!isFull || doPop);
  assign dropByte = strobe.push && isFull && !doPop;
  assign headData = isEmpty ? 8'h00 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strobe.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!strobe.flush && doPush) mem[wrPtr] <= strobe.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 overrunFlag <= 1'b0;
    else if (strobe.ovrClear)  overrunFlag <= 1'b0;
    else if (dropByte)         overrunFlag <= 1'b1;
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= FULL_CNT);
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (fifoCount == '0));
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !strobe.ovrClear) |=> overrunFlag);
  p_full_swap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && strobe.push && strobe.pop && !strobe.flush) |=> (fifoCount == FULL_CNT));

endmodule

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl
  import rfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rfifo_mode_e      modeReq,
  input  logic             packetMode,
  input  logic             bitTick,
  input  logic             rxBit,
  input  logic             hostWrEn,
  input  logic [7:0]       hostWrData,
  input  logic             hostRdEn,
  input  logic             ovrClrWr,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [7:0]       headData,
  output fifo_strobe_t     strobe,
  output logic             txBit,
  output logic             txBitValid,
  output logic             txDone,
  output logic             wrBytePulse
);

  rfifo_mode_e curMode;
  logic [7:0]  rxShift, txShift;
  logic [2:0]  rxCnt, txCnt;
  logic        txActive;
  logic        modeChange, restart, fifoHasData;
  logic        rxDone, hostPush, hostPop, txLoadIdle, txLastTick, txLoad;

  assign modeChange  = (modeReq != curMode);
  assign restart     = modeChange || ovrClrWr;
  assign fifoHasData = (fifoCount != '0);

  assign rxDone     = (curMode == MODE_RX) && bitTick && (rxCnt == 3'd7) && !restart;
  assign hostPush   = hostWrEn && ((curMode == MODE_STBY) || (curMode == MODE_TX));
  assign hostPop    = hostRdEn && (curMode != MODE_TX) && fifoHasData;
  assign txLoadIdle = (curMode == MODE_TX) && !txActive && fifoHasData && !restart;
  assign txLastTick = (curMode == MODE_TX) && txActive && bitTick && (txCnt == 3'd7) && !restart;
  assign txLoad     = txLoadIdle || (txLastTick && fifoHasData);

  always_comb begin
    strobe          = '0;
    strobe.push     = hostPush || rxDone;
    strobe.pushData = rxDone ? {rxShift[6:0], rxBit} : hostWrData;
    strobe.pop      = txLoad || hostPop;
    strobe.flush    = ovrClrWr || (modeChange && flushOnSwitch(curMode, modeReq, packetMode));
    strobe.ovrClear = ovrClrWr;
  end

  assign txBit      = txActive & txShift[7];
  assign txBitValid = txActive;

  always_ff @(posedge clk) begin
    if (!rstN) curMode <= MODE_SLEEP;
    else       curMode <= modeReq;
  end

  // Receive deserialiser
  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      rxShift     <= '0;
      rxCnt       <= '0;
      wrBytePulse <= 1'b0;
    end else if ((curMode == MODE_RX) && bitTick) begin
      rxShift     <= {rxShift[6:0], rxBit};
      rxCnt       <= rxCnt + 1'b1;
      wrBytePulse <= rxDone;
    end
  end

  // Transmit serialiser
  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      txShift  <= '0;
      txCnt    <= '0;
      txActive <= 1'b0;
      txDone   <= 1'b0;
    end else if (txLoad) begin
      txShift  <= headData;
      txCnt    <= '0;
      txActive <= 1'b1;
      txDone   <= 1'b0;
    end else if (txLastTick) begin
      txActive <= 1'b0;
      txDone   <= 1'b1;
    end else if ((curMode == MODE_TX) && txActive && bitTick) begin
      txShift  <= {txShift[6:0], 1'b0};
      txCnt    <= txCnt + 1'b1;
    end
  end

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !txActive);
  p_pulse_in_rx_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrBytePulse |-> (curMode == MODE_RX));
  p_valid_in_tx_r10: assert property (@(posedge clk) disable iff (!rstN)
    txBitValid |-> (curMode == MODE_TX));
  p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fifoHasData |-> !txLoad);

endmodule

// File: rtl/radio_fifo_irq.sv
module radio_fifo_irq
  import rfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             packetMode,
  input  logic             bitTick,
  input  logic             rxBit,
  input  logic             hostWrEn,
  input  logic [7:0]       hostWrData,
  input  logic             hostRdEn,
  output logic [7:0]       hostRdData,
  input  logic             ovrClrWr,
  input  logic [CNT_W-1:0] threshVal,
  output logic             txBit,
  output logic             txBitValid,
  output logic             emptyN,
  output logic             full,
  output logic             wrBytePulse,
  output logic             threshHit,
  output logic             overrun,
  output logic             txDone
);

  fifo_strobe_t     strobe;
  logic [CNT_W-1:0] fifoCount;
  logic [7:0]       headData;

  rfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .modeReq(rfifo_mode_e'(mode)), .packetMode(packetMode),
    .bitTick(bitTick), .rxBit(rxBit), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .ovrClrWr(ovrClrWr), .fifoCount(fifoCount), .headData(headData),
    .strobe(strobe), .txBit(txBit), .txBitValid(txBitValid), .txDone(txDone),
    .wrBytePulse(wrBytePulse)
  );

  rfifo_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoCount(fifoCount),
    .headData(headData), .overrunFlag(overrun)
  );

  assign hostRdData = headData;
  assign emptyN     = (fifoCount != '0);
  assign full       = (fifoCount == CNT_W'(DEPTH));
  assign threshHit  = (fifoCount > threshVal);

endmodule

// File: tb/tb_radio_fifo_irq.sv
module tb_radio_fifo_irq;
  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, packetMode = 1'b0, bitTick = 1'b0, rxBit = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, ovrClrWr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] hostWrData = 8'h00, hostRdData;
  logic [CW-1:0] threshVal = 7'd5;
  logic txBit, txBitValid, emptyN, full, wrBytePulse, threshHit, overrun, txDone;

  radio_fifo_irq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .mode(mode), .packetMode(packetMode), .bitTick(bitTick),
    .rxBit(rxBit), .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .ovrClrWr(ovrClrWr), .threshVal(threshVal), .txBit(txBit),
    .txBitValid(txBitValid), .emptyN(emptyN), .full(full), .wrBytePulse(wrBytePulse),
    .threshHit(threshHit), .overrun(overrun), .txDone(txDone)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] q[$];
  bit mOvr = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expEmptyN(int n); return (n != 0) ? 1 : 0; endfunction
  function automatic int expFull(int n); return (n == DEPTH) ? 1 : 0; endfunction
  function automatic int expThresh(int n, int t); return (n > t) ? 1 : 0; endfunction

  task automatic step(); @(posedge clk); #1; endtask

  task automatic checkModel();
    chk("R1 emptyN", emptyN, expEmptyN(q.size()));
    chk("R2 full", full, expFull(q.size()));
    chk("R3 threshHit", threshHit, expThresh(q.size(), int'(threshVal)));
    chk("R6 overrun", overrun, int'(mOvr));
  endtask

  task automatic setMode(input logic [1:0] m); mode = m; step(); endtask

  task automatic hostWrite(input logic [7:0] d);
    hostWrEn = 1'b1; hostWrData = d; step(); hostWrEn = 1'b0;
  endtask

  // model-tracked standby operation (wr, rd, clr may combine)
  task automatic sbyOp(input bit wr, input logic [7:0] d, input bit rd, input bit clr);
    bit popOk;
    hostWrEn = wr; hostWrData = d; hostRdEn = rd; ovrClrWr = clr;
    #1;
    if (rd) chk("R5 read data", hostRdData, (q.size() > 0) ? int'(q[0]) : 0);
    step();
    hostWrEn = 1'b0; hostRdEn = 1'b0; ovrClrWr = 1'b0;
    if (clr) begin q.delete(); mOvr = 0; end
    else begin
      popOk = rd && (q.size() > 0);
      if (wr && !(q.size() < DEPTH || popOk)) mOvr = 1;
      else if (wr) begin
        if (popOk) void'(q.pop_front());
        q.push_back(d);
        popOk = 0;
      end
      if (popOk) void'(q.pop_front());
    end
  endtask

  task automatic tick(input logic b); rxBit = b; bitTick = 1'b1; step(); bitTick = 1'b0; endtask

  task automatic rxByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick(b[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] txBytes [2];
    void'($urandom(32'd7721));
    repeat (3) step();
    rstN = 1'b1; step();
    // R1 reset state
    chk("R1 reset emptyN", emptyN, 0);
    chk("R1 reset full", full, 0);
    chk("R1 reset overrun", overrun, 0);
    chk("R1 reset txDone", txDone, 0);
    chk("R1 reset txBitValid", txBitValid, 0);
    chk("R1 reset wrBytePulse", wrBytePulse, 0);

    // R5 write ignored in sleep
    hostWrite(8'h55);
    chk("R5 sleep write ignored", emptyN, 0);
    setMode(2'd1);
    sbyOp(0, 8'h00, 1, 0);      // R5 empty read returns 0
    checkModel();

    // R1 R2 R3 fill with threshold 5
    for (int i = 0; i < DEPTH; i++) begin sbyOp(1, 8'(i + 1), 0, 0); checkModel(); end
    sbyOp(1, 8'hEE, 0, 0);      // R6 drop while full
    checkModel();
    chk("R6 overrun set", overrun, 1);
    sbyOp(0, 8'h00, 0, 1);      // R7 clear flushes
    chk("R7 overrun cleared", overrun, 0);
    chk("R7 flushed", emptyN, 0);

    // R12 swap on full
    for (int i = 0; i < DEPTH; i++) sbyOp(1, 8'(8'h80 + i), 0, 0);
    sbyOp(1, 8'h77, 1, 0);
    chk("R12 still full", full, 1);
    chk("R12 no overrun", overrun, 0);
    while (q.size() > 0) sbyOp(0, 8'h00, 1, 0);
    checkModel();

    // R8 standby->rx flush, R4 receive
    sbyOp(1, 8'h12, 0, 0); sbyOp(1, 8'h34, 0, 0);
    setMode(2'd2); q.delete();
    chk("R8 stby->rx flush", emptyN, 0);
    rxByte(8'hA5);
    chk("R4 pulse after byte", wrBytePulse, 1);
    chk("R4 byte pushed", emptyN, 1);
    step(); step();
    chk("R4 pulse held until tick", wrBytePulse, 1);
    tick(1'b0);
    chk("R4 pulse ends at tick", wrBytePulse, 0);
    hostWrite(8'h11);           // R5 ignored in rx
    setMode(2'd1); q.push_back(8'hA5);
    chk("R8 rx->stby kept", emptyN, 1);
    sbyOp(0, 8'h00, 1, 0);      // R4 data A5
    sbyOp(0, 8'h00, 1, 0);      // R5 rx write was ignored -> 0
    checkModel();

    // R8 rx->tx flush
    setMode(2'd2); rxByte(8'h5A);
    chk("R4 second byte", emptyN, 1);
    setMode(2'd3);
    chk("R8 rx->tx flush", emptyN, 0);
    step();
    chk("R10 idle no valid", txBitValid, 0);

    // R8 tx->rx flush
    hostWrite(8'h01); hostWrite(8'h02); hostWrite(8'h03);
    chk("R10 loaded valid", txBitValid, 1);
    chk("R8 tx holds data", emptyN, 1);
    setMode(2'd2);
    chk("R8 tx->rx flush", emptyN, 0);
    chk("R10 valid drops on change", txBitValid, 0);

    // R8 tx->stby kept
    setMode(2'd3);
    hostWrite(8'h21); hostWrite(8'h22); hostWrite(8'h23);
    setMode(2'd1); q.delete(); q.push_back(8'h22); q.push_back(8'h23);
    checkModel();
    sbyOp(0, 8'h00, 1, 0); sbyOp(0, 8'h00, 1, 0); sbyOp(0, 8'h00, 1, 0);
    checkModel();

    // R8 any->sleep
    sbyOp(1, 8'h44, 0, 0);
    setMode(2'd0); q.delete();
    chk("R8 ->sleep flush", emptyN, 0);
    setMode(2'd1);

    // R9 buffered standby->tx flush
    packetMode = 1'b0;
    sbyOp(1, 8'h66, 0, 0); sbyOp(1, 8'h67, 0, 0);
    setMode(2'd3); q.delete();
    chk("R9 buffered flush", emptyN, 0);
    step();
    chk("R9 nothing to send", txBitValid, 0);

    // R9 packet preload, R10 serial order, R11 done
    setMode(2'd1); packetMode = 1'b1;
    txBytes[0] = 8'h3C; txBytes[1] = 8'h81;
    sbyOp(1, txBytes[0], 0, 0); sbyOp(1, txBytes[1], 0, 0);
    setMode(2'd3);
    chk("R9 packet kept", emptyN, 1);
    step();
    for (int k = 0; k < 16; k++) begin
      chk("R10 txBitValid", txBitValid, 1);
      chk("R10 txBit", txBit, int'(txBytes[k / 8][7 - (k % 8)]));
      chk("R11 not done early", txDone, 0);
      tick(1'b0);
    end
    chk("R11 done", txDone, 1);
    chk("R10 valid low at end", txBitValid, 0);
    chk("R1 empty after send", emptyN, 0);
    setMode(2'd1); q.delete();
    chk("R11 clears on mode change", txDone, 0);

    // random standby traffic
    for (int c = 0; c < 1500; c++) begin
      bit w, r, z;
      if (c % 200 == 0) threshVal = 7'($urandom_range(0, 66));
      w = ($urandom_range(0, 99) < 60);
      r = ($urandom_range(0, 99) < 45);
      z = ($urandom_range(0, 199) == 0);
      sbyOp(w, 8'($urandom()), r, z);
      checkModel();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule